// File: doc/BRIEF.md
# MDIO Management Master with Register Control

This block lets software reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO bus. Software sees two 32-bit registers: a command word and a data word four bytes above it. The command word packs the PHY address, the PHY register address, the transfer direction, an MDC divider select and a busy flag. Software writes the command word with busy set to start one Clause 22 transfer. It then polls until busy clears. After a read, it takes the result from the data word.

During a transfer the block divides the bus clock down to MDC. It sends a 32-bit preamble of ones, then the start code, the opcode, both addresses and a turnaround, and then moves 16 data bits, all MSB first. MDC idles low and stays low whenever no transfer is in progress. The divider select should be programmed once after reset, before the first transfer. While a transfer runs, command writes are dropped.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset, both registers read 0, MDC is low and the block does not drive MDIO (mdio_oe = 0).
- R2: The command word reads back as: busy in bit 0, direction in bit 1 (1 = write, 0 = read), PHY register address in bits 8:4, PHY address in bits 16:12 and divider select in bits 21:20. Writing it with bit 0 clear only updates the fields.
- R3: A write transfer drives 64 MDC bit periods, sampled on MDC rising edges: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, then the 16 data-word bits. Every field is sent MSB first.
- R4: A read transfer sends opcode 10. It releases MDIO (mdio_oe = 0) from bit period 46 through 63, which covers the turnaround and the data. It samples mdio_i at each of the 16 data rising edges and puts the 16-bit result in bits 15:0 of the data word.
- R5: Divider select 0, 1, 2 and 3 give an MDC period of 16, 32, 64 and 128 bus clocks, high for exactly half of each period.
- R6: MDC is low and never toggles while busy is clear.
- R7: During a transfer, mdio_o changes only on the bus-clock edge at which MDC falls.
- R8: Busy reads 1 from the cycle after the start write until the end of the 64th bit period, then clears by itself. Command writes made while busy is set change no field and do not start another frame.
- R9: The data word at byte offset 4 is writable and reads back its low 16 bits. On a write transfer, those bits form the data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset (0 = command, 4 = data), used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions check four things on every cycle:
- MDC stays quiet while busy is clear.
- mdio_o moves only when MDC falls.
- The command fields stay frozen while busy is set.
- MDIO is driven only inside a frame.

Frame content, turnaround release, the captured read result, the four exact MDC periods and duty, and the absence of a second frame after a dropped command write can only be shown by the bench. It does this with a responder that decodes the serial stream and answers reads.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int CMD_BUSY_BIT = 0;
  localparam int CMD_DIR_BIT  = 1;
  localparam int CMD_REG_LSB  = 4;
  localparam int CMD_PHY_LSB  = 12;
  localparam int CMD_DIV_LSB  = 20;

  localparam int ADR_W     = 5;
  localparam int DATA_W    = 16;
  localparam int DIVSEL_W  = 2;
  localparam int NUM_DIV   = 1 << DIVSEL_W;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADR_W + 2 + DATA_W;
  localparam int TA_POS    = FRAME_LEN - DATA_W - 2;
  localparam int DATA_POS  = FRAME_LEN - DATA_W;
  localparam int BIT_CNT_W = $clog2(FRAME_LEN);

  typedef struct packed {
    logic [DIVSEL_W-1:0] div;
    logic [ADR_W-1:0]    phy;
    logic [ADR_W-1:0]    regad;
    logic                wr;
  } cmd_cfg_t;

  localparam int CFG_W = $bits(cmd_cfg_t);

  function automatic logic [FRAME_LEN-1:0] build_frame(cmd_cfg_t c,
                                                        logic [DATA_W-1:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] payload;
    op      = c.wr ? 2'b01 : 2'b10;
    ta      = c.wr ? 2'b10 : 2'b11;
    payload = c.wr ? d : {DATA_W{1'b1}};
    return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regad, ta, payload};
  endfunction

endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CMD_OFF  = 0,
  parameter int DATA_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_result,
  output logic              busy,
  output cmd_cfg_t          cfg,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFF);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFF);

  logic              busy_q, busy_d;
  cmd_cfg_t          cfg_q, cfg_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cmd_accept;
  logic [31:0]       cmd_word;

  assign cmd_accept = wr_en && (addr == CMD_A) && !busy_q;

  always_comb begin
    busy_d = busy_q;
    cfg_d  = cfg_q;
    data_d = data_q;
    if (cmd_accept) begin
      busy_d      = wdata[CMD_BUSY_BIT];
      cfg_d.wr    = wdata[CMD_DIR_BIT];
      cfg_d.regad = wdata[CMD_REG_LSB +: ADR_W];
      cfg_d.phy   = wdata[CMD_PHY_LSB +: ADR_W];
      cfg_d.div   = wdata[CMD_DIV_LSB +: DIVSEL_W];
    end else if (done) begin
      busy_d = 1'b0;
    end
    if (wr_en && (addr == DATA_A)) begin
      data_d = wdata[DATA_W-1:0];
    end
    if (done && !cfg_q.wr) begin
      data_d = rd_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cfg_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cfg_q  <= cfg_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    cmd_word                            = '0;
    cmd_word[CMD_BUSY_BIT]              = busy_q;
    cmd_word[CMD_DIR_BIT]               = cfg_q.wr;
    cmd_word[CMD_REG_LSB +: ADR_W]      = cfg_q.regad;
    cmd_word[CMD_PHY_LSB +: ADR_W]      = cfg_q.phy;
    cmd_word[CMD_DIV_LSB +: DIVSEL_W]   = cfg_q.div;
  end

  always_comb begin
    if (addr == CMD_A)       rdata = cmd_word;
    else if (addr == DATA_A) rdata = {{(32-DATA_W){1'b0}}, data_q};
    else                     rdata = '0;
  end

  assign busy    = busy_q;
  assign cfg     = cfg_q;
  assign wr_data = data_q;

endmodule

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [DIVSEL_W-1:0] div_sel,
  output logic                mdc,
  output logic                rise_stb,
  output logic                fall_stb
);

  localparam int CNT_W = DIV_BASE_LOG2 + NUM_DIV - 1;

  logic [CNT_W-1:0] full_lim [NUM_DIV];
  logic [CNT_W-1:0] half_lim [NUM_DIV];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_lim
    assign full_lim[g] = CNT_W'((1 << (DIV_BASE_LOG2 + g)) - 1);
    assign half_lim[g] = CNT_W'((1 << (DIV_BASE_LOG2 + g - 1)) - 1);
  end

  assign rise_stb = run && (cnt_q == half_lim[div_sel]);
  assign fall_stb = run && (cnt_q == full_lim[div_sel]);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (fall_stb) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      if (rise_stb) mdc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_cfg_t          cfg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              act,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [BIT_CNT_W-1:0] LAST_IDX = BIT_CNT_W'(FRAME_LEN - 1);
  localparam logic [BIT_CNT_W-1:0] TA_IDX   = BIT_CNT_W'(TA_POS);
  localparam logic [BIT_CNT_W-1:0] DATA_IDX = BIT_CNT_W'(DATA_POS);

  logic                 act_q, act_d;
  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic [BIT_CNT_W-1:0] idx_q, idx_d;
  logic                 wr_q, wr_d;
  logic [DATA_W-1:0]    rd_q, rd_d;

  assign done = act_q && fall_stb && (idx_q == LAST_IDX);

  always_comb begin
    act_d   = act_q;
    frame_d = frame_q;
    idx_d   = idx_q;
    wr_d    = wr_q;
    rd_d    = rd_q;
    if (start && !act_q) begin
      act_d   = 1'b1;
      frame_d = build_frame(cfg, wr_data);
      idx_d   = '0;
      wr_d    = cfg.wr;
    end else if (act_q) begin
      if (fall_stb) begin
        if (idx_q == LAST_IDX) begin
          act_d = 1'b0;
        end else begin
          idx_d   = idx_q + BIT_CNT_W'(1);
          frame_d = {frame_q[FRAME_LEN-2:0], 1'b1};
        end
      end
      if (rise_stb && !wr_q && (idx_q >= DATA_IDX)) begin
        rd_d = {rd_q[DATA_W-2:0], mdio_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      frame_q <= '1;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      act_q   <= act_d;
      frame_q <= frame_d;
      idx_q   <= idx_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
    end
  end

  assign act     = act_q;
  assign mdio_o  = act_q ? frame_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = act_q && (wr_q || (idx_q < TA_IDX));
  assign rd_data = rd_q;

endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int CMD_OFF       = 0,
  parameter int DATA_OFF      = 4,
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);

  logic              busy;
  cmd_cfg_t          cmd_cfg;
  logic [DATA_W-1:0] wr_word;
  logic [DATA_W-1:0] rd_word;
  logic              eng_act;
  logic              eng_done;
  logic              rise_stb;
  logic              fall_stb;

  mdio_mgmt_regs #(
    .ADDR_W   (ADDR_W),
    .CMD_OFF  (CMD_OFF),
    .DATA_OFF (DATA_OFF)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .done      (eng_done),
    .rd_result (rd_word),
    .busy      (busy),
    .cfg       (cmd_cfg),
    .wr_data   (wr_word)
  );

  mdio_mgmt_clkgen #(
    .DIV_BASE_LOG2 (DIV_BASE_LOG2)
  ) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (eng_act),
    .div_sel  (cmd_cfg.div),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_mgmt_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (busy && !eng_act),
    .cfg      (cmd_cfg),
    .wr_data  (wr_word),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .act      (eng_act),
    .done     (eng_done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_word)
  );

endmodule

// File: rtl/mgmt_serial_master_chk.sv
module mgmt_serial_master_chk
  import mdio_mgmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             act,
  input logic [CFG_W-1:0] cfg_bits
);

  // R6
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R7
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && (mdio_o != $past(mdio_o))) |-> (!mdc && $past(mdc)));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_bits));

  // R1
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> act);

endmodule

bind mgmt_serial_master mgmt_serial_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .busy     (busy),
  .act      (eng_act),
  .cfg_bits (cmd_cfg)
);

// File: tb/mgmt_serial_master_tb.sv
`timescale 1ns/1ps
module mgmt_serial_master_tb;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;

  int checks = 0;
  int failures = 0;

  int  rcnt = 0;
  bit  cap_en = 0;
  bit  [63:0] cap_o;
  bit  [63:0] cap_oe;
  logic [15:0] rsp_val = 16'h0;
  time t_rise = 0;
  int  pmin, pmax, hmin, hmax;
  int  viol = 0;
  logic last_o = 1'b1;
  int  total_rises = 0;

  mgmt_serial_master u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // PHY-side responder: turnaround zero, then 16 data bits MSB first
  assign mdio_i = (cap_en && !mdio_oe && rcnt >= 47 && rcnt <= 63) ?
                  ((rcnt == 47) ? 1'b0 : rsp_val[63 - rcnt]) : 1'b1;

  always @(posedge mdc) begin
    total_rises++;
    if (cap_en) begin
      if (rcnt < 64) begin
        cap_o[rcnt]  = mdio_o;
        cap_oe[rcnt] = mdio_oe;
      end
      if (rcnt > 0) begin
        int p;
        p = int'(($time - t_rise) / 4);
        if (p < pmin) pmin = p;
        if (p > pmax) pmax = p;
      end
      t_rise = $time;
      rcnt++;
    end
  end

  always @(negedge mdc) begin
    if (cap_en) begin
      int h;
      h = int'(($time - t_rise) / 4);
      if (h < hmin) hmin = h;
      if (h > hmax) hmax = h;
    end
  end

  always @(negedge clk) begin
    if (mdc && (mdio_o !== last_o)) viol++;
    last_o = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input int dv, input int phy,
                                           input int rg, input bit wr, input bit bsy);
    return (32'(dv) << 20) | (32'(phy) << 12) | (32'(rg) << 4) |
           (32'(wr) << 1) | 32'(bsy);
  endfunction

  function automatic logic [63:0] exp_frame(input int phy, input int rg,
                                            input bit wr, input logic [15:0] d);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), 5'(phy), 5'(rg),
         (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
    return f;
  endfunction

  task automatic wait_idle(input string req);
    logic [31:0] r;
    int n = 0;
    do begin
      reg_rd(4'h0, r);
      n++;
    end while (r[0] && n < 20000);
    chk(!r[0], req, "busy clears at end of frame", longint'(r[0]), 0);
  endtask

  task automatic run_xfer(input int dv, input int phy, input int rg, input bit wr,
                          input logic [15:0] d, input string tag);
    logic [31:0] r;
    logic [63:0] ef;
    int bad = 0;
    int half;
    if (wr) reg_wr(4'h4, {16'h0, d});
    rsp_val = d;
    rcnt = 0;
    pmin = 1 << 30; pmax = 0; hmin = 1 << 30; hmax = 0;
    viol = 0;
    cap_en = 1;
    reg_wr(4'h0, cmd_word(dv, phy, rg, wr, 1'b1));
    reg_rd(4'h0, r);
    chk(r[0] == 1'b1, "R8", {tag, " busy set after start"}, longint'(r[0]), 1);
    wait_idle("R8");
    cap_en = 0;
    chk(rcnt == 64, wr ? "R3" : "R4", {tag, " rising edge count"}, rcnt, 64);
    half = (16 << dv) / 2;
    chk(pmin == (16 << dv) && pmax == (16 << dv), "R5", {tag, " mdc period"},
        pmax, 16 << dv);
    chk(hmin == half && hmax == half, "R5", {tag, " mdc high time"}, hmax, half);
    chk(viol == 0, "R7", {tag, " mdio moves while mdc high"}, viol, 0);
    ef = exp_frame(phy, rg, wr, d);
    for (int i = 0; i < 64; i++) begin
      if (wr || i < 46) begin
        if (cap_oe[i] !== 1'b1 || cap_o[i] !== ef[63 - i]) bad++;
      end else begin
        if (cap_oe[i] !== 1'b0) bad++;
      end
    end
    chk(bad == 0, wr ? "R3" : "R4", {tag, " frame bits and drive"}, bad, 0);
    reg_rd(4'h4, r);
    chk(r == {16'h0, d}, wr ? "R9" : "R4", {tag, " data register"}, r, {16'h0, d});
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R6", {tag, " idle after frame"},
        {mdc, mdio_oe}, 0);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    reg_rd(4'h0, r);
    chk(r == 0, "R1", "command after reset", r, 0);
    reg_rd(4'h4, r);
    chk(r == 0, "R1", "data after reset", r, 0);
    chk(mdc == 0 && mdio_oe == 0, "R1", "pins after reset", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_fields;
    logic [31:0] r;
    int rises0;
    rises0 = total_rises;
    reg_wr(4'h0, cmd_word(3, 5'h15, 5'h0A, 1'b1, 1'b0));
    reg_rd(4'h0, r);
    chk(r == 32'h0031_50A2, "R2", "field readback", r, 32'h0031_50A2);
    repeat (300) @(negedge clk);
    chk(total_rises == rises0, "R6", "no mdc while not busy", total_rises, rises0);
    reg_wr(4'h4, 32'hDEAD_BEEF);
    reg_rd(4'h4, r);
    chk(r == 32'h0000_BEEF, "R9", "data register low half", r, 32'h0000_BEEF);
  endtask

  task automatic t_ignore;
    logic [31:0] r;
    logic [31:0] orig;
    orig = cmd_word(3, 5'h07, 5'h11, 1'b1, 1'b1);
    reg_wr(4'h4, 32'h0000_3C3C);
    rcnt = 0;
    cap_en = 1;
    reg_wr(4'h0, orig);
    repeat (2000) @(negedge clk);
    reg_wr(4'h0, cmd_word(0, 5'h1F, 5'h03, 1'b0, 1'b1));
    reg_rd(4'h0, r);
    chk(r == orig, "R8", "command write during busy dropped", r, orig);
    wait_idle("R8");
    repeat (400) @(negedge clk);
    cap_en = 0;
    chk(rcnt == 64, "R8", "no second frame", rcnt, 64);
    reg_rd(4'h0, r);
    chk(r == (orig & ~32'h1), "R8", "fields kept after frame", r, orig & ~32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_wr_en = 1'b0;
    reg_addr = 4'h0;
    reg_wdata = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    run_xfer(0, 5'h01, 5'h04, 1'b1, 16'hA55A, "wr div16");
    run_xfer(1, 5'h03, 5'h02, 1'b0, 16'h1234, "rd div32");
    run_xfer(2, 5'h1E, 5'h1F, 1'b0, 16'h8001, "rd div64");
    run_xfer(3, 5'h10, 5'h00, 1'b1, 16'hF00F, "wr div128");
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule